// File: doc/BRIEF.md
# Left-Aligned Pulse-Width Modulator with Register Access

This block produces one pulse-width modulated output from four word registers reached over a simple 32-bit read/write bus. Software loads a period and a duty value, both counted in prescaled clock ticks, and then starts the channel through the control word. While the channel runs, a counter steps from zero up to one less than the period and wraps. The output stays in its duty phase while the counter is below the duty value and in the opposite phase for the rest of the cycle.

The level of the duty phase and the level held while the channel is stopped are set by two separate control bits. Period and duty writes go into shadow copies. The running cycle only picks them up when the counter wraps, so a reprogrammed waveform never shows a torn cycle. The counter advances once every `PRESC` clocks, where `PRESC` is a build parameter.

Top module: `lapwm_top`

## Requirements
- R1: After reset, all four registers read 0 and `pwmOut` is 0.
- R2: Byte offset 0x04 holds the period and 0x08 holds the duty. Both read back the full 32-bit word last written. Offset 0x00 returns the live counter and ignores writes.
- R3: The control word sits at offset 0x0C. Bit 0 is enable, bit 1 is continuous mode, bit 3 is the duty-phase level (1 = high) and bit 4 is the stopped level (1 = high). All other bits read 0, including bit 5 (alignment, fixed at left) and bit 8 (low-power mode, fixed off).
- R4: The channel runs only when bits 0 and 1 are both set. Otherwise `pwmOut` equals bit 4 in the same cycle, and the counter reads 0 from the next cycle on.
- R5: In the cycle after the control write that starts the channel, the counter reads 0. It then steps by one per prescaled tick and wraps to 0 after reaching period−1.
- R6: While running, `pwmOut` equals bit 3 when the counter is below the duty value and the inverse of bit 3 otherwise.
- R7: Period or duty values written while the channel runs take effect only from the wrap that follows the write.
- R8: A duty of 0 gives a constant non-duty level, and a duty at or above the period gives a constant duty level. A period of 0 holds `pwmOut` at the stopped level with the counter at 0.
- R9: With `PRESC` = 2, the counter advances once every two clocks.
- R10: Period and duty values written while the channel is stopped apply from the first cycle after the channel is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from busAddr |
| pwmOut | output | 1 | Modulated output |

## Verification
A write lands in its register at the clock edge that samples it. Read data is combinational, so the bench drives the address at a falling edge and samples one time step later, well before the next rising edge. The counter first reads 0 on the falling edge after the enabling write, and `pwmOut` follows the counter within the same cycle. The bench therefore indexes every expected counter and output value by the number of falling edges since that write. It models the shadow handover by counting exactly which edge performs the wrap, and it checks the second instance (prescale 2) against half that edge count.

// File: rtl/lapwm_pkg.sv
package lapwm_pkg;
  // byte offsets of the word registers
  localparam int OFF_CNT    = 'h0;
  localparam int OFF_PERIOD = 'h4;
  localparam int OFF_DUTY   = 'h8;
  localparam int OFF_CTRL   = 'hC;

  // control bit positions
  localparam int BIT_EN     = 0;
  localparam int BIT_CONT   = 1;
  localparam int BIT_DUTYHI = 3;
  localparam int BIT_IDLEHI = 4;

  // writable control bits; alignment (5) and low-power (8) stay 0
  localparam int CTRL_MASK  = (1 << BIT_EN) | (1 << BIT_CONT) |
                              (1 << BIT_DUTYHI) | (1 << BIT_IDLEHI);

  typedef struct packed {
    logic run;
    logic dutyHigh;
    logic idleHigh;
  } pwmStrb_t;
endpackage

// File: rtl/lapwm_ctrl.sv
module lapwm_ctrl
  import lapwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] shPeriod,
  output logic [DATA_W-1:0] shDuty,
  output pwmStrb_t          strb
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(CTRL_MASK);

  logic [DATA_W-1:0] ctrlReg;
  logic              wrEn;

  assign wrEn = busSel && busWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shPeriod <= '0;
      shDuty   <= '0;
      ctrlReg  <= '0;
    end else if (wrEn) begin
      if (busAddr == ADDR_W'(OFF_PERIOD)) shPeriod <= busWdata;
      if (busAddr == ADDR_W'(OFF_DUTY))   shDuty   <= busWdata;
      if (busAddr == ADDR_W'(OFF_CTRL))   ctrlReg  <= busWdata & MASK;
    end
  end

  always_comb begin
    strb.run      = ctrlReg[BIT_EN] && ctrlReg[BIT_CONT];
    strb.dutyHigh = ctrlReg[BIT_DUTYHI];
    strb.idleHigh = ctrlReg[BIT_IDLEHI];
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFF_CNT))         busRdata = cntVal;
    else if (busAddr == ADDR_W'(OFF_PERIOD)) busRdata = shPeriod;
    else if (busAddr == ADDR_W'(OFF_DUTY))   busRdata = shDuty;
    else if (busAddr == ADDR_W'(OFF_CTRL))   busRdata = ctrlReg;
  end
endmodule

// File: rtl/lapwm_dp.sv
module lapwm_dp
  import lapwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRESC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrb_t          strb,
  input  logic [DATA_W-1:0] shPeriod,
  input  logic [DATA_W-1:0] shDuty,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] actPeriod,
  output logic [DATA_W-1:0] actDuty,
  output logic              pwmOut
);
  logic tick;
  logic wrap;

  generate
    if (PRESC <= 1) begin : g_noPresc
      assign tick = 1'b1;
    end else begin : g_presc
      localparam int PW = $clog2(PRESC);
      logic [PW-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !strb.run)              preCnt <= '0;
        else if (preCnt == PW'(PRESC - 1))   preCnt <= '0;
        else                                 preCnt <= preCnt + PW'(1);
      end
      assign tick = (preCnt == PW'(PRESC - 1));
    end
  endgenerate

  assign wrap = (actPeriod == '0) || (cnt >= actPeriod - DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      actPeriod <= '0;
      actDuty   <= '0;
    end else if (!strb.run) begin
      cnt       <= '0;
      actPeriod <= shPeriod;
      actDuty   <= shDuty;
    end else if (tick) begin
      if (wrap) begin
        cnt       <= '0;
        actPeriod <= shPeriod;
        actDuty   <= shDuty;
      end else begin
        cnt <= cnt + DATA_W'(1);
      end
    end
  end

  always_comb begin
    if (!strb.run || actPeriod == '0) pwmOut = strb.idleHigh;
    else if (cnt < actDuty)           pwmOut = strb.dutyHigh;
    else                              pwmOut = !strb.dutyHigh;
  end
endmodule

// File: rtl/lapwm_top.sv
module lapwm_top
  import lapwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int PRESC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              pwmOut
);
  pwmStrb_t          strb;
  logic [DATA_W-1:0] shPeriod;
  logic [DATA_W-1:0] shDuty;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] actPeriod;
  logic [DATA_W-1:0] actDuty;

  lapwm_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .cntVal(cnt),
    .busRdata(busRdata), .shPeriod(shPeriod), .shDuty(shDuty),
    .strb(strb)
  );

  lapwm_dp #(.DATA_W(DATA_W), .PRESC(PRESC)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .shPeriod(shPeriod),
    .shDuty(shDuty), .cnt(cnt), .actPeriod(actPeriod),
    .actDuty(actDuty), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/lapwm_chk.sv
module lapwm_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              run,
  input logic              dutyHigh,
  input logic              idleHigh,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] actP,
  input logic [DATA_W-1:0] actD,
  input logic              pwmOut
);
  // R4
  stopped_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> cnt == '0);

  // R4
  stopped_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> pwmOut == idleHigh);

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && actP != '0) |-> cnt < actP);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && cnt != '0) |->
      (cnt == $past(cnt) || cnt == $past(cnt) + DATA_W'(1)));

  // R7
  shadow_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(actP) || !$stable(actD)) |-> cnt == '0);

  // R6
  duty_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && actP != '0 && actD != '0 && cnt == '0) |-> pwmOut == dutyHigh);

  // R8
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && actP != '0 && actD == '0) |-> pwmOut != dutyHigh);
endmodule

bind lapwm_top lapwm_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .run(strb.run), .dutyHigh(strb.dutyHigh),
  .idleHigh(strb.idleHigh), .cnt(cnt), .actP(actPeriod), .actD(actDuty),
  .pwmOut(pwmOut)
);

// File: tb/sim_lapwm_top.sv
module sim_lapwm_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rd0, rd1;
  logic        out0, out1;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lapwm_top #(.PRESC(1)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rd0), .pwmOut(out0));

  lapwm_top #(.PRESC(2)) u1 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rd1), .pwmOut(out1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v0, output logic [31:0] v1);
    busAddr = a;
    #1;
    v0 = rd0;
    v1 = rd1;
  endtask

  task automatic setup(input int p, input int d);
    wr(4'h0C, 32'h0);
    wr(4'h04, p);
    wr(4'h08, d);
  endtask

  task automatic t_reset;
    logic [31:0] a, b;
    for (int i = 0; i < 16; i += 4) begin
      rd(i[3:0], a, b);
      chk("R1 reg", a, 0);
    end
    chk("R1 out", {31'b0, out0}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] a, b;
    wr(4'h04, 32'h1234_5678);
    wr(4'h08, 32'hABCD_EF01);
    rd(4'h04, a, b); chk("R2 period", a, 32'h1234_5678);
    rd(4'h08, a, b); chk("R2 duty", a, 32'hABCD_EF01);
    wr(4'h0C, 32'hFFFF_FFFC);
    rd(4'h0C, a, b); chk("R3 ctrl mask", a, 32'h18);
    chk("R4 idle high", {31'b0, out0}, 1);
    wr(4'h00, 32'h55);
    rd(4'h00, a, b); chk("R2 counter ro", a, 0);
    wr(4'h0C, 32'h0);
    chk("R4 idle low", {31'b0, out0}, 0);
  endtask

  task automatic t_basic;
    logic [31:0] a, b;
    setup(5, 2);
    wr(4'h0C, 32'h0B);
    for (int k = 0; k < 12; k++) begin
      rd(4'h00, a, b);
      chk("R5 R10 cnt", a, k % 5);
      chk("R6 out", {31'b0, out0}, ((k % 5) < 2) ? 1 : 0);
      chk("R9 cnt presc2", b, (k / 2) % 5);
      chk("R9 out presc2", {31'b0, out1}, (((k / 2) % 5) < 2) ? 1 : 0);
      @(negedge clk);
    end
    wr(4'h0C, 32'h0);
    chk("R4 stop out", {31'b0, out0}, 0);
    @(negedge clk);
    rd(4'h00, a, b); chk("R4 stop cnt", a, 0);
  endtask

  task automatic t_polarity;
    logic [31:0] a, b;
    setup(4, 1);
    wr(4'h0C, 32'h13);
    for (int k = 0; k < 8; k++) begin
      chk("R6 low duty", {31'b0, out0}, ((k % 4) < 1) ? 0 : 1);
      @(negedge clk);
    end
    wr(4'h0C, 32'h12);
    chk("R4 no enable out", {31'b0, out0}, 1);
    @(negedge clk);
    rd(4'h00, a, b); chk("R4 no enable cnt", a, 0);
    wr(4'h0C, 32'h11);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rd(4'h00, a, b); chk("R4 no continuous cnt", a, 0);
      chk("R4 no continuous out", {31'b0, out0}, 1);
    end
  endtask

  task automatic t_shadow;
    logic [31:0] a, b;
    setup(4, 2);
    wr(4'h0C, 32'h0B);
    @(negedge clk);
    wr(4'h04, 6);
    wr(4'h08, 3);
    rd(4'h00, a, b); chk("R7 old period cnt", a, 3);
    chk("R7 old duty out", {31'b0, out0}, 0);
    @(negedge clk);
    for (int k = 4; k < 16; k++) begin
      rd(4'h00, a, b);
      chk("R7 new cnt", a, (k - 4) % 6);
      chk("R7 new out", {31'b0, out0}, (((k - 4) % 6) < 3) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_edges;
    logic [31:0] a, b;
    setup(4, 0);
    wr(4'h0C, 32'h0B);
    for (int k = 0; k < 8; k++) begin
      chk("R8 zero duty", {31'b0, out0}, 0);
      @(negedge clk);
    end
    setup(4, 7);
    wr(4'h0C, 32'h0B);
    for (int k = 0; k < 8; k++) begin
      chk("R8 full duty", {31'b0, out0}, 1);
      @(negedge clk);
    end
    setup(0, 3);
    wr(4'h0C, 32'h13);
    for (int k = 0; k < 6; k++) begin
      rd(4'h00, a, b);
      chk("R8 zero period cnt", a, 0);
      chk("R8 zero period out", {31'b0, out0}, 1);
      @(negedge clk);
    end
    wr(4'h0C, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_basic();
    t_polarity();
    t_shadow();
    t_edges();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule